// File: doc/BRIEF.md
# Locked Bus Cycle Sequencer

This block runs an atomic read-modify-write on a processor bus that sits beside a write-back cache. A request carries the operand address, a flag saying the operand crosses into the next cache line, and the data to write to each half. When the request is taken, the block looks up the state of every line the operand touches. Clean copies (Shared or Exclusive) are invalidated at once. Dirty copies (Modified) are first written back to memory in a burst and then invalidated. After that the block reads each half and writes each half, with the lock output asserted for all of those cycles.

The lock output has defined behaviour in several cases. It stays asserted through an address hold. It is released to high impedance while the bus is backed off. It is released again while a hold request is granted between two sequences. A locked read always finishes after a single transfer, even when the cache-enable input is active, so it never turns into a line fill. A new request may start on the same edge that ends the previous sequence, with no idle clock in between. The cache array, the data path that modifies the operand, and snoop handling are outside the block. A two-entry line-state lookup port stands in for the cache.

Top module: `locked_rmw_seq`

## Requirements
- R1: While reset is held and in the first clock after reset: `addrStrobe`=0, `lockOut`=0, `lockOe`=1, `holdAck`=0 and `reqAccept`=0.
- R2: Each bus cycle lasts at least two clocks and raises `addrStrobe` only in its first clock. The cycles come in this order, and a cycle is issued only if it applies:
  - write-back of the low line, at the low line base, when that line is Modified;
  - write-back of the high line, at the low base plus the line size, when the operand is split and that line is Modified;
  - locked read of the low half, at the request address;
  - locked read of the high half, at the high line base, when the operand is split;
  - locked write of the low half, at the request address;
  - locked write of the high half, at the high line base, when the operand is split.
  `wrRd` is 0 for reads and 1 for writes and write-backs.
- R3: `lockOut` is 1 in every clock of a locked read or locked write cycle and 0 in every clock of a write-back cycle.
- R4: The line-state codes are 0 Invalid, 1 Shared, 2 Exclusive and 3 Modified. `lkAddrLo` and `lkAddrHi` show the line bases of `reqAddr`. In the first clock of the sequence, `invValid` bit 0 (low line) and bit 1 (high line, split operands only) pulse for lines in state 1 or 2. For a Modified line, its bit pulses in the clock after its write-back completes. `invAddrLo` and `invAddrHi` give the line bases. A line in state 0 is never invalidated.
- R5: A locked read completes on the first edge where `rdy` or `brdy` is 1, even when `ken` is 1. The next cycle's strobe follows in the next clock. `rdLo` and `rdHi` hold the data captured by the low and high reads.
- R6: A write-back completes on `rdy`, or after WB_BEATS edges with `brdy` set. It is never completed by `ken`.
- R7: While `ahold` is 1, `addrOe` is 0 and `lockOut` keeps its value. The running cycle continues.
- R8: When `boff` is 1 at an edge during a bus cycle, the next clock has `lockOe`=0 and no strobe. After `boff` returns to 0, the same cycle restarts with a strobe, the same address, and `lockOe`=1 with `lockOut` driven to its value for that cycle.
- R9: When a request is waiting as the last locked write completes, the next sequence's first strobe comes in the very next clock. If that sequence opens with a read, `lockOut` stays 1 across the boundary.
- R10: `holdReq` is granted only from idle or at the end of a sequence, and it takes priority over a pending request. `holdAck` rises in the next clock. `lockOe` is 0 while `holdAck` is 1. Idle is entered in the clock after `holdReq` falls.
- R11: `reqAccept` is 1 only in idle, or on the completing edge of a sequence's last cycle, when `reqValid` is 1 and `holdReq` is 0.
- R12: During locked write cycles, `busWdata` carries `reqWdLo` for the low half and `reqWdHi` for the high half, as captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request pending; held until accepted |
| reqAddr | input | AW | Operand address |
| reqSplit | input | 1 | Operand crosses into the next line |
| reqWdLo | input | DW | Write data for the low half |
| reqWdHi | input | DW | Write data for the high half |
| reqAccept | output | 1 | Request taken on this edge |
| seqDone | output | 1 | Last cycle of the sequence completes on this edge |
| lkAddrLo | output | AW | Lookup address, low line |
| lkAddrHi | output | AW | Lookup address, high line |
| lkStateLo | input | 2 | State of the low line |
| lkStateHi | input | 2 | State of the high line |
| invValid | output | 2 | Invalidate pulse per line |
| invAddrLo | output | AW | Low line base of the running sequence |
| invAddrHi | output | AW | High line base of the running sequence |
| ahold | input | 1 | Address hold |
| boff | input | 1 | Back-off |
| holdReq | input | 1 | Bus hold request |
| rdy | input | 1 | Single-transfer ready |
| brdy | input | 1 | Burst ready |
| ken | input | 1 | Cache-enable returned by memory |
| rdData | input | DW | Read data |
| addrStrobe | output | 1 | Address strobe, first clock of a cycle |
| addrOe | output | 1 | Address bus drive enable |
| busAddr | output | AW | Cycle address |
| wrRd | output | 1 | 1 write, 0 read |
| busWdata | output | DW | Locked write data |
| lockOut | output | 1 | Lock, active high |
| lockOe | output | 1 | Lock drive enable; 0 means high impedance |
| holdAck | output | 1 | Hold acknowledge |
| rdLo | output | DW | Data captured by the low read |
| rdHi | output | DW | Data captured by the high read |

## Verification
The assertions assume the following about the inputs:
- `reqValid` stays high until it is accepted.
- `rdy` and `brdy` are driven only during the waiting clocks of a cycle.
- The lookup states are stable while a request is pending.

The bench keeps to these rules by construction. Its bus responder raises a ready only after it has seen the strobe plus a random number of wait clocks. It drives the lookup state and the next request together, before the final write of a chained sequence. Back-off, address hold and hold requests are placed at chosen cycles of random sequences, never on the accept edge.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } lineSt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_BOFF,
    ST_HOLD
  } seqSt_t;

  // Step codes: 0/1 write-back lo/hi, 2/3 locked read lo/hi, 4/5 locked write lo/hi
  localparam int STEP_W = 3;

  typedef struct packed {
    logic              load;
    logic              capLo;
    logic              capHi;
    logic [STEP_W-1:0] step;
  } dpCtl_t;

endpackage

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int WB_BEATS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqSplit,
  input  logic [1:0] lkStateLo,
  input  logic [1:0] lkStateHi,
  input  logic       ahold,
  input  logic       boff,
  input  logic       holdReq,
  input  logic       rdy,
  input  logic       brdy,
  input  logic       ken,
  output logic       reqAccept,
  output logic       seqDone,
  output logic       addrStrobe,
  output logic       addrOe,
  output logic       wrRd,
  output logic       lockOut,
  output logic       lockOe,
  output logic       holdAck,
  output logic [1:0] invValid,
  output dpCtl_t     dpCtl
);

  localparam int BW = (WB_BEATS > 1) ? $clog2(WB_BEATS) : 1;
  localparam logic [BW-1:0] LAST_BEAT = BW'(WB_BEATS - 1);

  seqSt_t              state, nState;
  logic [5:0]          stepMask, nMask;
  logic [STEP_W-1:0]   step, nStep;
  logic [BW-1:0]       beat, nBeat;
  logic [1:0]          invQ, nInv;

  logic       kindWb, kindRd, inCycle, cycDone, lastDone, canTake, goHold;
  logic [5:0] remMask, newMask;
  logic       cleanLo, cleanHi;

  function automatic logic [STEP_W-1:0] firstStep(input logic [5:0] m);
    firstStep = '0;
    for (int i = 5; i >= 0; i--) begin
      if (m[i]) firstStep = STEP_W'(i);
    end
  endfunction

  assign kindWb  = (step < STEP_W'(2));
  assign kindRd  = (step == STEP_W'(2)) || (step == STEP_W'(3));
  assign inCycle = (state == ST_T1) || (state == ST_T2);

  always_comb begin
    if (state != ST_T2 || boff)      cycDone = 1'b0;
    else if (kindWb)                 cycDone = rdy || (brdy && beat == LAST_BEAT);
    else                             cycDone = rdy || brdy;
  end

  assign remMask  = stepMask & ~(6'd1 << step);
  assign lastDone = cycDone && (remMask == 6'd0);
  assign canTake  = (state == ST_IDLE) || lastDone;
  assign goHold   = canTake && holdReq;
  assign reqAccept = canTake && !holdReq && reqValid;
  assign seqDone  = lastDone;

  // Plan bits: 5 wr hi, 4 wr lo, 3 rd hi, 2 rd lo, 1 wb hi, 0 wb lo
  assign newMask = {reqSplit, 1'b1, reqSplit, 1'b1,
                    reqSplit && (lkStateHi == LS_M), (lkStateLo == LS_M)};
  assign cleanLo = (lkStateLo == LS_S) || (lkStateLo == LS_E);
  assign cleanHi = reqSplit && ((lkStateHi == LS_S) || (lkStateHi == LS_E));

  always_comb begin
    nState = state;
    nMask  = stepMask;
    nStep  = step;
    nBeat  = beat;
    nInv   = 2'b00;
    case (state)
      ST_IDLE: begin
        if (goHold) nState = ST_HOLD;
        else if (reqAccept) begin
          nState = ST_T1;
          nMask  = newMask;
          nStep  = firstStep(newMask);
          nBeat  = '0;
        end
      end
      ST_T1: nState = boff ? ST_BOFF : ST_T2;
      ST_T2: begin
        if (boff) nState = ST_BOFF;
        else if (cycDone) begin
          if (kindWb) nInv[step[0]] = 1'b1;
          if (remMask == 6'd0) begin
            if (goHold) nState = ST_HOLD;
            else if (reqAccept) begin
              nState = ST_T1;
              nMask  = newMask;
              nStep  = firstStep(newMask);
              nBeat  = '0;
            end else nState = ST_IDLE;
          end else begin
            nState = ST_T1;
            nMask  = remMask;
            nStep  = firstStep(remMask);
            nBeat  = '0;
          end
        end else if (brdy && kindWb) nBeat = beat + 1'b1;
      end
      ST_BOFF: begin
        if (!boff) begin
          nState = ST_T1;
          nBeat  = '0;
        end
      end
      ST_HOLD: if (!holdReq) nState = ST_IDLE;
      default: nState = ST_IDLE;
    endcase
    if (reqAccept) nInv = {cleanHi, cleanLo};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepMask <= '0;
      step     <= '0;
      beat     <= '0;
      invQ     <= '0;
    end else begin
      state    <= nState;
      stepMask <= nMask;
      step     <= nStep;
      beat     <= nBeat;
      invQ     <= nInv;
    end
  end

  assign addrStrobe = (state == ST_T1);
  assign addrOe     = !ahold;
  assign wrRd       = !kindRd;
  assign lockOut    = (inCycle || state == ST_BOFF) && !kindWb;
  assign lockOe     = !((state == ST_BOFF) || (state == ST_HOLD));
  assign holdAck    = (state == ST_HOLD);
  assign invValid   = invQ;

  assign dpCtl.load  = reqAccept;
  assign dpCtl.capLo = cycDone && (step == STEP_W'(2));
  assign dpCtl.capHi = cycDone && (step == STEP_W'(3));
  assign dpCtl.step  = step;

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrStrobe |=> !addrStrobe);

  // R5
  no_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T2 && kindRd && ken && brdy && !boff) |=> (state != ST_T2));

  // R7
  ahold_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && lockOe && ahold && !boff && !rdy && !brdy) |=> lockOut);

  // R8
  boff_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inCycle && boff) |=> (!lockOe && !addrStrobe));

  // R10
  hold_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && holdReq) |=> (holdAck && !lockOe));

  // R11
  accept_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |-> (reqValid && !holdReq && !(inCycle && !cycDone)));

endmodule

// File: rtl/lrs_dpath.sv
module lrs_dpath
  import lrs_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdLo,
  input  logic [DW-1:0] reqWdHi,
  input  logic [DW-1:0] rdData,
  output logic [AW-1:0] lkAddrLo,
  output logic [AW-1:0] lkAddrHi,
  output logic [AW-1:0] invAddrLo,
  output logic [AW-1:0] invAddrHi,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic [DW-1:0] rdLo,
  output logic [DW-1:0] rdHi
);

  localparam int OFFW = $clog2(LINE_BYTES);
  localparam logic [AW-1:0] LINE_STEP = AW'(LINE_BYTES);
  localparam logic [AW-1:0] BASE_MASK = ~(LINE_STEP - AW'(1));

  logic [AW-1:0] loBase, hiBase, opAddr;
  logic [DW-1:0] wdLo, wdHi;
  logic [DW-1:0] rdQ [2];
  logic [1:0]    capV;

  assign lkAddrLo = reqAddr & BASE_MASK;
  assign lkAddrHi = (reqAddr & BASE_MASK) + LINE_STEP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loBase <= '0;
      hiBase <= '0;
      opAddr <= '0;
      wdLo   <= '0;
      wdHi   <= '0;
    end else if (ctl.load) begin
      loBase <= lkAddrLo;
      hiBase <= lkAddrHi;
      opAddr <= reqAddr;
      wdLo   <= reqWdLo;
      wdHi   <= reqWdHi;
    end
  end

  assign capV = {ctl.capHi, ctl.capLo};

  for (genvar g = 0; g < 2; g++) begin : g_rdLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        rdQ[g] <= '0;
      else if (capV[g]) rdQ[g] <= rdData;
    end
  end

  assign rdLo = rdQ[0];
  assign rdHi = rdQ[1];

  always_comb begin
    case (ctl.step)
      STEP_W'(0):              busAddr = loBase;
      STEP_W'(2), STEP_W'(4):  busAddr = opAddr;
      default:                 busAddr = hiBase;
    endcase
  end

  assign busWdata  = (ctl.step == STEP_W'(5)) ? wdHi : wdLo;
  assign invAddrLo = loBase;
  assign invAddrHi = hiBase;

  // R5
  one_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(capV));

  // R4
  line_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (invAddrHi == invAddrLo + LINE_STEP) && (invAddrLo[OFFW-1:0] == '0));

endmodule

// File: rtl/locked_rmw_seq.sv
module locked_rmw_seq
  import lrs_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 16,
  parameter int WB_BEATS   = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic          reqSplit,
  input  logic [DW-1:0] reqWdLo,
  input  logic [DW-1:0] reqWdHi,
  output logic          reqAccept,
  output logic          seqDone,
  output logic [AW-1:0] lkAddrLo,
  output logic [AW-1:0] lkAddrHi,
  input  logic [1:0]    lkStateLo,
  input  logic [1:0]    lkStateHi,
  output logic [1:0]    invValid,
  output logic [AW-1:0] invAddrLo,
  output logic [AW-1:0] invAddrHi,
  input  logic          ahold,
  input  logic          boff,
  input  logic          holdReq,
  input  logic          rdy,
  input  logic          brdy,
  input  logic          ken,
  input  logic [DW-1:0] rdData,
  output logic          addrStrobe,
  output logic          addrOe,
  output logic [AW-1:0] busAddr,
  output logic          wrRd,
  output logic [DW-1:0] busWdata,
  output logic          lockOut,
  output logic          lockOe,
  output logic          holdAck,
  output logic [DW-1:0] rdLo,
  output logic [DW-1:0] rdHi
);

  dpCtl_t dpCtl;

  lrs_ctrl #(.WB_BEATS(WB_BEATS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSplit(reqSplit),
    .lkStateLo(lkStateLo), .lkStateHi(lkStateHi), .ahold(ahold), .boff(boff),
    .holdReq(holdReq), .rdy(rdy), .brdy(brdy), .ken(ken),
    .reqAccept(reqAccept), .seqDone(seqDone), .addrStrobe(addrStrobe),
    .addrOe(addrOe), .wrRd(wrRd), .lockOut(lockOut), .lockOe(lockOe),
    .holdAck(holdAck), .invValid(invValid), .dpCtl(dpCtl)
  );

  lrs_dpath #(.AW(AW), .DW(DW), .LINE_BYTES(LINE_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .reqAddr(reqAddr),
    .reqWdLo(reqWdLo), .reqWdHi(reqWdHi), .rdData(rdData),
    .lkAddrLo(lkAddrLo), .lkAddrHi(lkAddrHi), .invAddrLo(invAddrLo),
    .invAddrHi(invAddrHi), .busAddr(busAddr), .busWdata(busWdata),
    .rdLo(rdLo), .rdHi(rdHi)
  );

endmodule

// File: tb/locked_rmw_seq_tb.sv
module locked_rmw_seq_tb;

  localparam int LINE  = 16;
  localparam int BEATS = 4;

  logic        clk = 0, rstN = 0;
  logic        reqValid = 0, reqSplit = 0;
  logic [15:0] reqAddr = 0;
  logic [31:0] reqWdLo = 0, reqWdHi = 0, rdData = 0;
  logic [1:0]  lkStateLo = 0, lkStateHi = 0;
  logic        ahold = 0, boff = 0, holdReq = 0, rdy = 0, brdy = 0, ken = 0;
  logic        reqAccept, seqDone, addrStrobe, addrOe, wrRd, lockOut, lockOe, holdAck;
  logic [1:0]  invValid;
  logic [15:0] lkAddrLo, lkAddrHi, invAddrLo, invAddrHi, busAddr;
  logic [31:0] busWdata, rdLo, rdHi;

  int nChk = 0, nFail = 0;
  logic finished = 0;

  // current and next request, plus per-sequence options
  logic [15:0] cA, nA, curLo, curHi;
  logic        cSp, nSp;
  logic [1:0]  cSLo, cSHi, nSLo, nSHi;
  logic [31:0] cWdLo, cWdHi, nWdLo, nWdHi;
  logic        haveNext = 0, holdAtEnd = 0, kenOn = 0, useBrdy = 0;
  int          boffIdx = -1, aholdIdx = -1;

  always #10 clk = ~clk;

  locked_rmw_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqSplit(reqSplit),
    .reqWdLo(reqWdLo), .reqWdHi(reqWdHi), .reqAccept(reqAccept), .seqDone(seqDone),
    .lkAddrLo(lkAddrLo), .lkAddrHi(lkAddrHi), .lkStateLo(lkStateLo), .lkStateHi(lkStateHi),
    .invValid(invValid), .invAddrLo(invAddrLo), .invAddrHi(invAddrHi), .ahold(ahold),
    .boff(boff), .holdReq(holdReq), .rdy(rdy), .brdy(brdy), .ken(ken), .rdData(rdData),
    .addrStrobe(addrStrobe), .addrOe(addrOe), .busAddr(busAddr), .wrRd(wrRd),
    .busWdata(busWdata), .lockOut(lockOut), .lockOe(lockOe), .holdAck(holdAck),
    .rdLo(rdLo), .rdHi(rdHi)
  );

  function automatic logic [15:0] lineBase(input logic [15:0] a);
    return a & ~16'(LINE - 1);
  endfunction

  task automatic chkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one bus cycle; entered at the negedge of its first clock.
  task automatic busCycle(input int idx, input logic [15:0] expAddr, input logic [1:0] expInv,
                          input logic isLast, input logic expAcc, input logic [31:0] expWd,
                          output logic [31:0] rdVal);
    logic expLock;
    int   waits;
    expLock = (idx >= 2);
    rdVal = $urandom;
    chkEq("R2 strobe", addrStrobe, 1);
    chkEq("R2 addr", busAddr, expAddr);
    chkEq("R2 wrRd", wrRd, (idx < 2 || idx >= 4));
    chkEq("R3 lock", lockOut, expLock);
    chkEq("R3 lockOe", lockOe, 1);
    chkEq("R4 inv", invValid, expInv);
    if (expInv[0]) chkEq("R4 invAddrLo", invAddrLo, curLo);
    if (expInv[1]) chkEq("R4 invAddrHi", invAddrHi, curHi);
    chkEq("R11 noAccept", reqAccept, 0);
    if (idx >= 4) chkEq("R12 wdata", busWdata, expWd);
    if (idx == boffIdx) begin
      boff = 1;
      @(negedge clk);
      chkEq("R8 float", lockOe, 0);
      chkEq("R8 nostrobe", addrStrobe, 0);
      @(negedge clk);
      chkEq("R8 float2", lockOe, 0);
      boff = 0;
      @(negedge clk);
      chkEq("R8 restart", addrStrobe, 1);
      chkEq("R8 addr", busAddr, expAddr);
      chkEq("R8 lock", lockOut, expLock);
      chkEq("R8 lockOe", lockOe, 1);
    end
    if (idx == aholdIdx) ahold = 1;
    @(negedge clk);
    waits = $urandom % 3;
    for (int w = 0; w < waits; w++) begin
      chkEq("R3 lockWait", lockOut, expLock);
      chkEq("R2 noStrobe", addrStrobe, 0);
      chkEq("R11 noAcceptWait", reqAccept, 0);
      if (ahold) begin
        chkEq("R7 addrOe", addrOe, 0);
        chkEq("R7 lock", lockOut, expLock);
      end
      @(negedge clk);
    end
    if (idx < 2 && useBrdy) begin
      for (int b = 0; b < BEATS; b++) begin
        brdy = 1;
        #1;
        chkEq("R6 wbLock", lockOut, 0);
        chkEq("R6 noStrobe", addrStrobe, 0);
        @(negedge clk);
      end
      brdy = 0;
    end else begin
      if (idx >= 2 && useBrdy) brdy = 1; else rdy = 1;
      if (idx == 2 || idx == 3) ken = kenOn;
      rdData = rdVal;
      if (isLast && holdAtEnd) holdReq = 1;
      #1;
      chkEq("R11 accept", reqAccept, expAcc);
      chkEq("R9 seqDone", seqDone, isLast);
      if (ahold) chkEq("R7 lockEnd", lockOut, expLock);
      @(negedge clk);
      rdy = 0; brdy = 0; ken = 0;
    end
    ahold = 0;
  endtask

  task automatic runSeq(input logic chained);
    logic [5:0]  m;
    logic [1:0]  pendInv;
    logic [15:0] addr;
    logic [31:0] rv, rdLoE, rdHiE;
    int          lastIdx;
    rdLoE = 0; rdHiE = 0;
    curLo = lineBase(cA);
    curHi = curLo + 16'(LINE);
    if (!chained) begin
      reqAddr = cA; reqSplit = cSp; reqWdLo = cWdLo; reqWdHi = cWdHi;
      lkStateLo = cSLo; lkStateHi = cSHi; reqValid = 1;
      #1;
      chkEq("R11 idleAccept", reqAccept, 1);
      chkEq("R4 lkLo", lkAddrLo, curLo);
      chkEq("R4 lkHi", lkAddrHi, curHi);
      @(negedge clk);
    end
    reqValid = 0;
    m = {cSp, 1'b1, cSp, 1'b1, cSp && (cSHi == 2'd3), (cSLo == 2'd3)};
    lastIdx = cSp ? 5 : 4;
    pendInv = {cSp && (cSHi == 2'd1 || cSHi == 2'd2), (cSLo == 2'd1 || cSLo == 2'd2)};
    for (int i = 0; i < 6; i++) begin
      if (m[i]) begin
        if (i == 2 || i == 4) addr = cA;
        else if (i % 2 == 1)  addr = curHi;
        else                  addr = curLo;
        if (i == lastIdx && haveNext) begin
          reqAddr = nA; reqSplit = nSp; reqWdLo = nWdLo; reqWdHi = nWdHi;
          lkStateLo = nSLo; lkStateHi = nSHi; reqValid = 1;
        end
        busCycle(i, addr, pendInv, (i == lastIdx), (i == lastIdx) && haveNext && !holdAtEnd,
                 (i == 5) ? cWdHi : cWdLo, rv);
        pendInv = (i < 2) ? (2'b01 << i) : 2'b00;
        if (i == 2) rdLoE = rv;
        if (i == 3) rdHiE = rv;
      end
    end
    chkEq("R5 rdLo", rdLo, rdLoE);
    if (cSp) chkEq("R5 rdHi", rdHi, rdHiE);
  endtask

  task automatic pickNext();
    nA = 16'($urandom); nSp = $urandom % 2; nSLo = 2'($urandom); nSHi = 2'($urandom);
    nWdLo = $urandom; nWdHi = $urandom;
  endtask

  task automatic takeNext();
    cA = nA; cSp = nSp; cSLo = nSLo; cSHi = nSHi; cWdLo = nWdLo; cWdHi = nWdHi;
  endtask

  task automatic holdRelease();
    chkEq("R10 holdAck", holdAck, 1);
    chkEq("R10 lockFloat", lockOe, 0);
    holdReq = 0;
    @(negedge clk);
    chkEq("R10 holdDrop", holdAck, 0);
    chkEq("R10 lockDriven", lockOe, 1);
  endtask

  task automatic setReq(input logic [15:0] a, input logic sp, input logic [1:0] sl,
                        input logic [1:0] sh);
    cA = a; cSp = sp; cSLo = sl; cSHi = sh; cWdLo = $urandom; cWdHi = $urandom;
  endtask

  initial begin
    logic chained;
    void'($urandom(32'h1ce5));
    repeat (3) @(negedge clk);
    chkEq("R1 strobe", addrStrobe, 0);
    chkEq("R1 lock", lockOut, 0);
    chkEq("R1 lockOe", lockOe, 1);
    chkEq("R1 holdAck", holdAck, 0);
    rstN = 1;
    @(negedge clk);
    chkEq("R1 strobeOut", addrStrobe, 0);
    chkEq("R1 lockOut", lockOut, 0);
    chkEq("R1 accept", reqAccept, 0);

    // aligned, invalid line: one read then one write (R2, R3)
    setReq(16'h1234, 0, 2'd0, 2'd0);
    runSeq(0);
    // split, both lines dirty, burst write-backs (R2, R3, R4, R6)
    useBrdy = 1;
    setReq(16'h20fe, 1, 2'd3, 2'd3);
    runSeq(0);
    // split, clean lines, reads return ken with brdy (R4, R5)
    kenOn = 1;
    setReq(16'h33fc, 1, 2'd1, 2'd2);
    runSeq(0);
    kenOn = 0; useBrdy = 0;
    // back-off on low read, address hold on low write (R7, R8)
    boffIdx = 2; aholdIdx = 4;
    setReq(16'h4ffa, 1, 2'd0, 2'd1);
    runSeq(0);
    boffIdx = 5; aholdIdx = 0;
    setReq(16'h5008, 1, 2'd3, 2'd0);
    runSeq(0);
    boffIdx = -1; aholdIdx = -1;
    // back-to-back with lock held across the boundary (R9)
    setReq(16'h6000, 0, 2'd0, 2'd0);
    nA = 16'h7002; nSp = 0; nSLo = 2'd0; nSHi = 2'd0; nWdLo = 32'hbeef; nWdHi = 0;
    haveNext = 1;
    runSeq(0);
    chkEq("R9 lockHeld", lockOut, 1);
    haveNext = 0;
    takeNext();
    runSeq(1);
    // hold at idle beats a pending request (R10)
    setReq(16'h8010, 0, 2'd2, 2'd0);
    reqAddr = cA; reqValid = 1; holdReq = 1;
    #1;
    chkEq("R10 holdFirst", reqAccept, 0);
    @(negedge clk);
    holdRelease();
    runSeq(0);
    // hold between sequences (R10)
    setReq(16'h9000, 0, 2'd0, 2'd0);
    holdAtEnd = 1;
    runSeq(0);
    holdAtEnd = 0;
    holdRelease();

    // random sequences
    pickNext();
    takeNext();
    chained = 0;
    for (int n = 0; n < 40; n++) begin
      pickNext();
      haveNext  = (n < 39) && ($urandom % 3 == 0);
      holdAtEnd = !haveNext && ($urandom % 5 == 0);
      kenOn     = $urandom % 2;
      useBrdy   = $urandom % 2;
      boffIdx   = ($urandom % 4 == 0) ? int'($urandom % 6) : -1;
      aholdIdx  = ($urandom % 4 == 0) ? int'($urandom % 6) : -1;
      runSeq(chained);
      if (holdAtEnd) holdRelease();
      holdAtEnd = 0;
      chained = haveNext;
      takeNext();
      if (!chained) repeat ($urandom % 3) @(negedge clk);
    end
    haveNext = 0;
    boffIdx = -1; aholdIdx = -1;

    @(negedge clk);
    chkEq("R1 idleEnd", addrStrobe, 0);
    chkEq("R3 idleLock", lockOut, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule